// File: doc/BRIEF.md
# Legacy System Control Port Block

This block is an 8-bit I/O peripheral on a simple bus with an address, separate read and write strobes, write data and read data. It answers three single-byte ports. The control port at 0x92 holds one byte. Bit 1 of that byte drives the address-line-20 gate. Writing a byte with bit 0 set sends a one-cycle system reset request.

The port at 0xF0 belongs to a coprocessor error latch. An error strobe from the floating-point unit sets the latch, and the latch drives an interrupt line. Any write to 0xF0 clears the latch. The port at 0x80 is a diagnostic sink. Writes to it are dropped. Reads of 0xF0 and 0x80 return all ones.

The block has two resets. A power-on reset clears all of its state. A warm device reset clears only the reset-request bit of the control byte.

Top module: `sysctl_ports`

## Requirements
- R1: A write to address 0x92 stores the whole write-data byte in the control register. A read of 0x92 returns the stored byte unchanged, with `rd_valid` high.
- R2: `a20_gate` always equals bit 1 of the stored control byte.
- R3: A write to 0x92 with bit 0 set raises `sys_reset_req` for exactly one cycle. The pulse is registered on the clock edge that captures the write. A write with bit 0 clear gives no pulse.
- R4: While `por` is high, the control byte, `sys_reset_req` and `ferr_irq` are all cleared to 0.
- R5: A clock edge with `rst` high and `por` low clears bit 0 of the control byte and cancels any reset pulse. Bits 7..1 keep their values. A control write in the same cycle is ignored.
- R6: A clock edge with `fpu_err_set` high sets `ferr_irq`. The line then stays high until it is cleared under R7. `rst` does not affect it.
- R7: A write to 0xF0 clears `ferr_irq` on that clock edge, whatever the data value.
- R8: If `fpu_err_set` and a write to 0xF0 happen in the same cycle, the set wins and `ferr_irq` is high after that edge.
- R9: Reads of 0xF0 and of 0x80 return 0xFF with `rd_valid` high. A write to 0x80 changes no output and no stored state.
- R10: An access to any address other than 0x92, 0xF0 or 0x80 changes no state. A read of such an address gives `rd_valid` low and `rdata` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears all state |
| rst | input | 1 | Warm device reset, synchronous, active high |
| addr | input | ADDR_W | I/O address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| rd_valid | output | 1 | High when a read hits one of the three ports |
| fpu_err_set | input | 1 | Error strobe from the floating-point unit |
| a20_gate | output | 1 | Address-line-20 gate enable |
| sys_reset_req | output | 1 | One-cycle system reset request |
| ferr_irq | output | 1 | Coprocessor error interrupt line |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that every input is driven to a known value from the first clock edge, while `por` is still high. The stimulus keeps to this in three ways. It changes inputs only at falling edges. It issues each bus access as a single strobe. It holds `por` high for several cycles before the first access. The address sweep for unclaimed ports stays inside the low 256 addresses, where every decoded port lies, and it always writes a byte with bit 0 set, so a decode fault would show up as a reset pulse or a changed control byte.

// File: rtl/sysctl_ports.sv
module sysctl_ports #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h92,
  parameter logic [ADDR_W-1:0] FERR_ADDR = 'hF0,
  parameter logic [ADDR_W-1:0] DIAG_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rd_valid,
  input  logic              fpu_err_set,
  output logic              a20_gate,
  output logic              sys_reset_req,
  output logic              ferr_irq
);
  logic [7:0] ctrl_q;
  logic       pulse_q;
  logic       ferr_q;

  logic hit_ctrl, hit_ferr, hit_diag;
  assign hit_ctrl = (addr == CTRL_ADDR);
  assign hit_ferr = (addr == FERR_ADDR);
  assign hit_diag = (addr == DIAG_ADDR);

  logic ctrl_wr, ferr_wr;
  assign ctrl_wr = wr_en & hit_ctrl;
  assign ferr_wr = wr_en & hit_ferr;

  always_ff @(posedge clk) begin
    if (por) begin
      ctrl_q  <= '0;
      pulse_q <= 1'b0;
    end else if (rst) begin
      ctrl_q[0] <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      pulse_q <= ctrl_wr & wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (por)              ferr_q <= 1'b0;
    else if (fpu_err_set) ferr_q <= 1'b1;
    else if (ferr_wr)     ferr_q <= 1'b0;
  end

  assign rd_valid = rd_en & (hit_ctrl | hit_ferr | hit_diag);
  assign rdata    = !rd_valid ? 8'h00 : (hit_ctrl ? ctrl_q : 8'hFF);

  assign a20_gate      = ctrl_q[1];
  assign sys_reset_req = pulse_q;
  assign ferr_irq      = ferr_q;
endmodule

// File: rtl/sysctl_ports_chk.sv
module sysctl_ports_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h92,
  parameter logic [ADDR_W-1:0] FERR_ADDR = 'hF0,
  parameter logic [ADDR_W-1:0] DIAG_ADDR = 'h80
) (
  input logic              clk,
  input logic              por,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              rd_valid,
  input logic              fpu_err_set,
  input logic              a20_gate,
  input logic              sys_reset_req,
  input logic              ferr_irq
);
  logic c_wr, f_wr, known;
  assign c_wr  = wr_en && addr == CTRL_ADDR;
  assign f_wr  = wr_en && addr == FERR_ADDR;
  assign known = addr == CTRL_ADDR || addr == FERR_ADDR || addr == DIAG_ADDR;

  // R2
  a20_follow_chk: assert property (@(posedge clk) disable iff (por)
    (c_wr && !rst) |=> a20_gate == $past(wdata[1]));

  // R3
  pulse_cause_chk: assert property (@(posedge clk) disable iff (por)
    sys_reset_req |-> $past(c_wr && wdata[0] && !rst));

  // R5
  warm_keep_chk: assert property (@(posedge clk) disable iff (por)
    rst |=> $stable(a20_gate) && !sys_reset_req);

  // R6
  ferr_set_chk: assert property (@(posedge clk) disable iff (por)
    fpu_err_set |=> ferr_irq);

  // R7
  ferr_hold_chk: assert property (@(posedge clk) disable iff (por)
    (ferr_irq && !f_wr) |=> ferr_irq);

  // R10
  unclaimed_rd_chk: assert property (@(posedge clk) disable iff (por)
    (rd_en && !known) |-> (!rd_valid && rdata == 8'h00));
endmodule

bind sysctl_ports sysctl_ports_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .FERR_ADDR(FERR_ADDR), .DIAG_ADDR(DIAG_ADDR)
) chk_i (
  .clk(clk), .por(por), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .fpu_err_set(fpu_err_set),
  .a20_gate(a20_gate), .sys_reset_req(sys_reset_req), .ferr_irq(ferr_irq)
);

// File: tb/sysctl_ports_tb.sv
module sysctl_ports_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, por = 1, rst = 0, rd_en = 0, wr_en = 0, fpu_err_set = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rd_valid, a20_gate, sys_reset_req, ferr_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_ports #(.ADDR_W(AW)) dut_i (
    .clk(clk), .por(por), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .fpu_err_set(fpu_err_set),
    .a20_gate(a20_gate), .sys_reset_req(sys_reset_req), .ferr_irq(ferr_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req, input int exp, input int expv);
    @(negedge clk); addr = a; rd_en = 1;
    #1;
    chk(req, rdata, exp);
    chk(req, rd_valid, expv);
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    por = 0;
    // R4: state after power-on reset
    chk("R4 a20", a20_gate, 0);
    chk("R4 req", sys_reset_req, 0);
    chk("R4 irq", ferr_irq, 0);
    rd('h92, "R4 ctrl", 0, 1);

    // R1 R2 R3: every control byte
    for (int d = 0; d < 256; d++) begin
      wr('h92, d[7:0]);
      chk("R3 pulse", sys_reset_req, d & 1);
      chk("R2 a20", a20_gate, (d >> 1) & 1);
      @(negedge clk);
      chk("R3 single", sys_reset_req, 0);
      rd('h92, "R1 readback", d, 1);
    end

    // R5: warm reset clears only bit 0
    wr('h92, 8'hFF);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rd('h92, "R5 warm", 'hFE, 1);
    chk("R5 a20", a20_gate, 1);
    // R5: write during warm reset is ignored
    @(negedge clk); rst = 1; wr_en = 1; addr = 'h92; wdata = 8'h01;
    @(negedge clk); rst = 0; wr_en = 0;
    chk("R5 nopulse", sys_reset_req, 0);
    rd('h92, "R5 ignore", 'hFE, 1);
    // R4: power-on reset clears all
    @(negedge clk); por = 1;
    @(negedge clk); por = 0;
    rd('h92, "R4 por", 0, 1);

    // R6 R7: error latch
    for (int d = 0; d < 256; d += 51) begin
      @(negedge clk); fpu_err_set = 1;
      @(negedge clk); fpu_err_set = 0;
      chk("R6 set", ferr_irq, 1);
      @(negedge clk); @(negedge clk);
      chk("R6 hold", ferr_irq, 1);
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      chk("R6 rst", ferr_irq, 1);
      wr('hF0, d[7:0]);
      chk("R7 clear", ferr_irq, 0);
    end
    // R8: set wins
    @(negedge clk); fpu_err_set = 1; wr_en = 1; addr = 'hF0; wdata = 8'h00;
    @(negedge clk); fpu_err_set = 0; wr_en = 0;
    chk("R8 setwins", ferr_irq, 1);

    // R9: diagnostic and error port reads and writes
    rd('hF0, "R9 f0", 'hFF, 1);
    rd('h80, "R9 80", 'hFF, 1);
    wr('h92, 8'hA6);
    wr('h80, 8'hFF);
    chk("R9 req", sys_reset_req, 0);
    chk("R9 irq", ferr_irq, 1);
    rd('h92, "R9 ctrl", 'hA6, 1);

    // R10: unclaimed addresses
    for (int a = 0; a < 256; a++) begin
      if (a == 'h92 || a == 'hF0 || a == 'h80) continue;
      wr(a[AW-1:0], 8'hFF);
      chk("R10 req", sys_reset_req, 0);
      if (a % 16 == 3) rd(a[AW-1:0], "R10 rd", 0, 0);
    end
    wr('h1092, 8'h01);
    chk("R10 high", sys_reset_req, 0);
    chk("R10 irq", ferr_irq, 1);
    rd('h92, "R10 ctrl", 'hA6, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule